// File: doc/BRIEF.md
# Learning Ethernet Forwarding Engine

This block makes the forwarding decision for every frame that enters a small Ethernet switch. For each frame the datapath presents the ingress port number and the frame's source and destination MAC addresses for one cycle. The engine records which port the source address was seen on. It then looks up the destination address and returns a port bitmask together with a decision kind. The kind says whether the frame goes to one port, is flooded, or is discarded.

Each port belongs to one VLAN, and a VLAN forms one broadcast domain. The VLAN of each port and the set of trunk ports are fixed by parameters. A trunk port belongs to every VLAN. A flood reaches every member of the ingress port's domain except the ingress port itself. A frame whose destination was learned on a port outside that domain is dropped, because routing between VLANs is left to other logic.

The station table is a fully associative memory of 16 entries. When it is full, a new address takes the place of the entry that was written longest ago. The decision comes out a fixed two cycles after the request, marked by a one-cycle `done` pulse. A store-and-forward datapath and a cut-through datapath can both use it. The engine has no MAC address of its own and never adds to or changes a frame.

Top module: `l2_fwd_engine`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0, `fwd_mask` is all zeros and `fwd_kind` is 0. Reset also empties the station table.
- R2: A request presented in cycle t produces exactly one `done` pulse, in cycle t+2. `done` is low in every cycle that has no request two cycles before it. Requests may arrive in consecutive cycles.
- R3: A unicast destination that is not in the table gives `fwd_kind`=2 (flood). `fwd_mask` then holds every port of the ingress port's domain except the ingress port. With the default parameters, ports 0-3 form VLAN 0, ports 4-6 form VLAN 1 and port 7 is a trunk.
- R4: The destination ff:ff:ff:ff:ff:ff is always flooded (kind 2), using the same mask as in R3.
- R5: A source address learned from a request is found by any request presented in the following cycle or later. A hit on a port inside the ingress domain gives `fwd_kind`=1 (unicast), with a one-hot `fwd_mask` on the learned port.
- R6: The frame is dropped (`fwd_kind`=0, `fwd_mask`=0) when the destination was learned on the ingress port. It is also dropped when the destination equals the frame's own unicast source address.
- R7: The frame is dropped when the destination was learned on a port outside the ingress port's domain.
- R8: A trunk port belongs to every VLAN. Floods from access ports include it. A flood that enters on a trunk covers every other port. Unicast to and from a trunk is allowed in any VLAN.
- R9: When a known source address appears on a different port, the existing entry moves to that port. No second entry is created for the address.
- R10: The table holds 16 addresses. Learning a 17th distinct address replaces the entry that was written longest ago, and the other 15 entries stay intact.
- R11: A source address with the group bit set (bit 40 of the 48-bit value, the least significant bit of the first octet) is never learned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A frame header is presented this cycle |
| req_port | input | 3 | Ingress port number |
| req_src_mac | input | 48 | Source MAC address |
| req_dst_mac | input | 48 | Destination MAC address |
| done | output | 1 | One-cycle pulse: the decision is valid |
| fwd_mask | output | 8 | Destination port bitmask |
| fwd_kind | output | 2 | 0 drop, 1 unicast, 2 flood |

## Verification
The hardest condition to reach is replacement in a full table. Showing which entry was evicted takes queries that do not disturb the table themselves, since every ordinary query teaches the table its own source address. The stimulus resets the engine and fills all 16 entries from one port. It adds a 17th address, then sends its queries with a group source address, which R11 keeps out of the table. Back-to-back requests also check that a source learned in one cycle is already visible to the next request.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int MAC_W = 48;
  typedef logic [MAC_W-1:0] mac_t;

  typedef enum logic [1:0] {
    FWD_DROP    = 2'd0,
    FWD_UNICAST = 2'd1,
    FWD_FLOOD   = 2'd2
  } fwd_kind_e;

  // Group (multicast/broadcast) addresses carry bit 40 set.
  function automatic logic mac_is_group(mac_t m);
    return m[40];
  endfunction

  function automatic logic mac_is_bcast(mac_t m);
    return &m;
  endfunction

endpackage

// File: rtl/fwd_cam.sv
module fwd_cam
  import fwd_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  mac_t              src_mac,
  input  mac_t              dst_mac,
  output logic              dst_hit,
  output logic [PORT_W-1:0] dst_port
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  ent_valid;
  mac_t              ent_mac  [DEPTH];
  logic [PORT_W-1:0] ent_port [DEPTH];
  logic [IDX_W-1:0]  wr_ptr;

  logic [DEPTH-1:0]  src_match;
  logic [DEPTH-1:0]  dst_match;
  logic [IDX_W-1:0]  src_idx;
  logic [IDX_W-1:0]  dst_idx;

  // Named learning events
  logic learn_en;
  logic learn_hit;
  logic learn_new;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign src_match[i] = ent_valid[i] && (ent_mac[i] == src_mac);
    assign dst_match[i] = ent_valid[i] && (ent_mac[i] == dst_mac);
  end

  always_comb begin
    src_idx = '0;
    dst_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (src_match[i]) src_idx = IDX_W'(i);
      if (dst_match[i]) dst_idx = IDX_W'(i);
    end
  end

  assign learn_en  = req_valid && !mac_is_group(src_mac);
  assign learn_hit = |src_match;
  assign learn_new = learn_en && !learn_hit;

  assign dst_hit  = |dst_match;
  assign dst_port = ent_port[dst_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      wr_ptr    <= '0;
    end else if (learn_new) begin
      ent_valid[wr_ptr] <= 1'b1;
      wr_ptr <= (wr_ptr == IDX_W'(DEPTH-1)) ? '0 : IDX_W'(wr_ptr + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (learn_new) begin
      ent_mac[wr_ptr]  <= src_mac;
      ent_port[wr_ptr] <= req_port;
    end else if (learn_en && learn_hit) begin
      ent_port[src_idx] <= req_port;
    end
  end

  // R9: an address never occupies two entries
  a_r9_unique_src: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_match));
  a_r9_unique_dst: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dst_match));

  // R9: a moved station keeps its entry and takes the new port
  a_r9_move_port: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_en && learn_hit) |=> (ent_port[$past(src_idx)] == $past(req_port))
                                && $stable(ent_valid) && $stable(wr_ptr));

  // R5: a newly learned address sits in the victim slot next cycle
  a_r5_learn_visible: assert property (@(posedge clk) disable iff (!rst_n)
    learn_new |=> ent_valid[$past(wr_ptr)] && (ent_mac[$past(wr_ptr)] == $past(src_mac)));

  // R11: group sources leave the table untouched
  a_r11_no_group_learn: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mac_is_group(src_mac)) |=> $stable(ent_valid) && $stable(wr_ptr));

endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
  import fwd_pkg::*;
#(
  parameter int                     NPORTS     = 8,
  parameter int                     PORT_W     = 3,
  parameter int                     VID_W      = 1,
  parameter logic [NPORTS*VID_W-1:0] PORT_VLAN = 8'b0111_0000,
  parameter logic [NPORTS-1:0]      TRUNK_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  mac_t              src_mac,
  input  mac_t              dst_mac,
  input  logic              dst_hit,
  input  logic [PORT_W-1:0] dst_port,
  output logic              done,
  output logic [NPORTS-1:0] fwd_mask,
  output logic [1:0]        fwd_kind
);

  // Ports sharing a broadcast domain with 'ing', the ingress itself excluded.
  function automatic logic [NPORTS-1:0] domain_of(logic [PORT_W-1:0] ing);
    logic [NPORTS-1:0] d;
    for (int p = 0; p < NPORTS; p++) begin
      d[p] = TRUNK_MASK[p] || TRUNK_MASK[ing] ||
             (PORT_VLAN[p*VID_W +: VID_W] == PORT_VLAN[int'(ing)*VID_W +: VID_W]);
    end
    d[ing] = 1'b0;
    return d;
  endfunction

  // Stage 1: lookup result captured
  logic              s1_valid;
  logic [PORT_W-1:0] s1_port;
  logic              s1_bcast;
  logic              s1_self;
  logic              s1_hit;
  logic [PORT_W-1:0] s1_dport;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_port  <= '0;
      s1_bcast <= 1'b0;
      s1_self  <= 1'b0;
      s1_hit   <= 1'b0;
      s1_dport <= '0;
    end else begin
      s1_valid <= req_valid;
      s1_port  <= req_port;
      s1_bcast <= mac_is_bcast(dst_mac);
      s1_self  <= (src_mac == dst_mac) && !mac_is_group(src_mac);
      s1_hit   <= dst_hit;
      s1_dport <= dst_port;
    end
  end

  // Stage 2: decision
  logic [NPORTS-1:0] flood_mask;
  logic              dst_in_domain;
  logic              dst_is_ingress;
  logic [NPORTS-1:0] nxt_mask;
  fwd_kind_e         nxt_kind;

  assign flood_mask     = domain_of(s1_port);
  assign dst_in_domain  = flood_mask[s1_dport];
  assign dst_is_ingress = (s1_dport == s1_port);

  always_comb begin
    nxt_mask = '0;
    nxt_kind = FWD_DROP;
    if (s1_bcast || (!s1_self && !s1_hit)) begin
      nxt_mask = flood_mask;
      nxt_kind = FWD_FLOOD;
    end else if (s1_self || dst_is_ingress || !dst_in_domain) begin
      nxt_kind = FWD_DROP;
    end else begin
      nxt_mask[s1_dport] = 1'b1;
      nxt_kind = FWD_UNICAST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      fwd_mask <= '0;
      fwd_kind <= FWD_DROP;
    end else begin
      done     <= s1_valid;
      fwd_mask <= s1_valid ? nxt_mask : '0;
      fwd_kind <= s1_valid ? nxt_kind : FWD_DROP;
    end
  end

  // R2: fixed two-cycle latency in both directions
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 done);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid, 2));

  // R3/R6: the ingress port never appears in the result
  a_r3_no_hairpin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fwd_mask[$past(s1_port)]);

  // R5: unicast is exactly one port
  a_r5_unicast_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fwd_kind == FWD_UNICAST) |-> $onehot(fwd_mask));

  // R6/R7: a drop carries an empty mask
  a_r6_drop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fwd_kind == FWD_DROP) |-> (fwd_mask == '0));

  // R1: idle outputs are quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (fwd_mask == '0) && (fwd_kind == FWD_DROP));

endmodule

// File: rtl/l2_fwd_engine.sv
module l2_fwd_engine
  import fwd_pkg::*;
#(
  parameter int                      NPORTS     = 8,
  parameter int                      DEPTH      = 16,
  parameter int                      VID_W      = 1,
  parameter logic [NPORTS*VID_W-1:0] PORT_VLAN  = 8'b0111_0000,
  parameter logic [NPORTS-1:0]       TRUNK_MASK = 8'h80,
  localparam int                     PORT_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [47:0]       req_src_mac,
  input  logic [47:0]       req_dst_mac,
  output logic              done,
  output logic [NPORTS-1:0] fwd_mask,
  output logic [1:0]        fwd_kind
);

  logic              lk_hit;
  logic [PORT_W-1:0] lk_port;

  fwd_cam #(
    .DEPTH (DEPTH),
    .PORT_W(PORT_W)
  ) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_port (req_port),
    .src_mac  (req_src_mac),
    .dst_mac  (req_dst_mac),
    .dst_hit  (lk_hit),
    .dst_port (lk_port)
  );

  fwd_decide #(
    .NPORTS    (NPORTS),
    .PORT_W    (PORT_W),
    .VID_W     (VID_W),
    .PORT_VLAN (PORT_VLAN),
    .TRUNK_MASK(TRUNK_MASK)
  ) u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_port (req_port),
    .src_mac  (req_src_mac),
    .dst_mac  (req_dst_mac),
    .dst_hit  (lk_hit),
    .dst_port (lk_port),
    .done     (done),
    .fwd_mask (fwd_mask),
    .fwd_kind (fwd_kind)
  );

endmodule

// File: tb/l2_fwd_engine_bench.sv
module l2_fwd_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_port = '0;
  logic [47:0] req_src_mac = '0;
  logic [47:0] req_dst_mac = '0;
  logic        done;
  logic [7:0]  fwd_mask;
  logic [1:0]  fwd_kind;

  always #4 clk = ~clk;  // 125 MHz

  l2_fwd_engine u_l2_fwd_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_src_mac(req_src_mac), .req_dst_mac(req_dst_mac),
    .done(done), .fwd_mask(fwd_mask), .fwd_kind(fwd_kind)
  );

  localparam logic [1:0] K_DROP = 2'd0, K_UNI = 2'd1, K_FLOOD = 2'd2;
  localparam logic [7:0] DOM0 = 8'h8F, DOM1 = 8'hF0, DOMT = 8'hFF;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] GRP   = 48'h0100_5E00_0001;

  typedef struct {
    logic [1:0] kind;
    logic [7:0] mask;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic ok, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] flood_from(logic [7:0] dom, int p);
    return dom & ~(8'h01 << p);
  endfunction

  function automatic logic [47:0] mac(int n);
    return 48'h0200_0000_0000 + 48'(n);
  endfunction

  // Driver: one request per call, in the cycle after the previous one
  task automatic send(int port, logic [47:0] src, logic [47:0] dst,
                      logic [1:0] kind, logic [7:0] mask, string tag);
    exp_t e;
    @(negedge clk);
    req_valid   = 1'b1;
    req_port    = 3'(port);
    req_src_mac = src;
    req_dst_mac = dst;
    e.kind = kind; e.mask = mask; e.cyc = cyc + 2; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected done", 1'b0, 64'(done), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " decision"}, {fwd_kind, fwd_mask} == {e.kind, e.mask},
              64'({fwd_kind, fwd_mask}), 64'({e.kind, e.mask}));
        check("R2 latency", cyc == e.cyc, 64'(cyc), 64'(e.cyc));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", {done, fwd_mask, fwd_kind} == '0, 64'({done, fwd_mask, fwd_kind}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {done, fwd_mask, fwd_kind} == '0, 64'({done, fwd_mask, fwd_kind}), 64'd0);

    // Learning, flooding, VLAN isolation (back-to-back)
    send(0, mac(1), mac(2), K_FLOOD, flood_from(DOM0, 0), "R3 unknown flood vlan0");
    send(1, mac(2), mac(1), K_UNI,   8'h01,               "R5 learned next cycle");
    send(4, mac(3), mac(4), K_FLOOD, flood_from(DOM1, 4), "R3 unknown flood vlan1");
    send(4, mac(3), mac(1), K_DROP,  8'h00,               "R7 cross-vlan drop");
    send(0, mac(1), mac(2), K_UNI,   8'h02,               "R5 unicast to port1");
    send(2, mac(5), BCAST,  K_FLOOD, flood_from(DOM0, 2), "R4 broadcast vlan0");
    send(5, mac(6), BCAST,  K_FLOOD, flood_from(DOM1, 5), "R4 broadcast vlan1");
    send(1, mac(2), mac(2), K_DROP,  8'h00,               "R6 self address");
    send(1, mac(7), mac(2), K_DROP,  8'h00,               "R6 learned on ingress");
    // Trunk
    send(7, mac(8), mac(9), K_FLOOD, flood_from(DOMT, 7), "R8 flood from trunk");
    send(5, mac(6), mac(8), K_UNI,   8'h80,               "R8 unicast to trunk vlan1");
    send(7, mac(8), mac(3), K_UNI,   8'h10,               "R8 trunk to vlan1 host");
    send(7, mac(8), mac(1), K_UNI,   8'h01,               "R8 trunk to vlan0 host");
    // Station move
    send(3, mac(1), mac(10), K_FLOOD, flood_from(DOM0, 3), "R9 move flood");
    send(1, mac(2), mac(1),  K_UNI,   8'h08,               "R9 moved station");
    // Group source
    send(2, GRP,    mac(1),  K_UNI,   8'h08,               "R11 group src forwards");
    send(0, mac(11), GRP,    K_FLOOD, flood_from(DOM0, 0), "R11 group not learned");
    idle_drain();

    // Capacity and replacement from an empty table
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset mid-run", {done, fwd_mask, fwd_kind} == '0, 64'({done, fwd_mask, fwd_kind}), 64'd0);
    rst_n = 1'b1;
    send(1, GRP, mac(1), K_FLOOD, flood_from(DOM0, 1), "R1 table emptied");
    for (int i = 0; i < 17; i++)
      send(0, mac(100 + i), BCAST, K_FLOOD, flood_from(DOM0, 0), "R10 fill");
    send(1, GRP, mac(100), K_FLOOD, flood_from(DOM0, 1), "R10 oldest evicted");
    send(1, GRP, mac(101), K_UNI,   8'h01,               "R10 second kept");
    send(1, GRP, mac(115), K_UNI,   8'h01,               "R10 sixteenth kept");
    send(1, GRP, mac(116), K_UNI,   8'h01,               "R10 newest present");
    idle_drain();

    repeat (3) @(negedge clk);
    check("R2 quiet when idle", done == 1'b0, 64'(done), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule